// File: doc/BRIEF.md
# Lane Neighbour Exchange Network

This block is the register-to-register interconnect of a row of `LANES` processing lanes. Each lane presents one `WIDTH`-bit register value. On an operation strobe the network computes, for every lane, a new value taken from the lane itself, from its lower-index neighbour or from its upper-index neighbour. The result is registered and appears one clock later. No lane ever reads anything beyond its two immediate neighbours.

Three data movements are offered. Every value can step one lane toward index 0, or one lane toward the top index. Alternatively, adjacent lanes can be grouped into pairs that trade values, with a phase bit choosing which pairing is used. Each strobe also selects the topology. In the open-row topology the controller supplies the value that enters at whichever end is vacated. In the closed-loop topology the two ends are joined, so the value leaving one end enters the other.

A per-lane write enable lets the controller freeze some lanes. A frozen lane keeps its own value, but its value still reaches its neighbours. Lane k occupies bits `[k*WIDTH +: WIDTH]` of the packed vectors. `LANES` must be even.

Top module: `lane_xchg_net`

## Requirements
- R1: While `rst` is high, `lane_out` becomes all zeros on the next clock edge.
- R2: `lane_out` changes only on the clock edge that samples `op_valid` high. With `op_valid` low it holds its previous value.
- R3: Operation code 2'b00 (hold) loads every lane with its own `lane_in` value.
- R4: Operation code 2'b01 (move down) gives each enabled lane k < LANES-1 the value of lane k+1.
- R5: Operation code 2'b10 (move up) gives each enabled lane k > 0 the value of lane k-1.
- R6: With `ring_mode` = 0, move down loads the top lane from `edge_in_hi`, and move up loads lane 0 from `edge_in_lo`.
- R7: With `ring_mode` = 1, move down loads the top lane from lane 0, and move up loads lane 0 from the top lane. The edge inputs are not used.
- R8: Operation code 2'b11 (pair swap) with `cross_phase` = 0 swaps lanes (0,1), (2,3), and so on.
- R9: Pair swap with `cross_phase` = 1 swaps lanes (1,2), (3,4), and so on. With `ring_mode` = 0, lane 0 and the top lane keep their own values. With `ring_mode` = 1, the top lane and lane 0 form a pair.
- R10: A lane whose `lane_en` bit is 0 loads its own `lane_in` value. Its value is still delivered to the neighbours that read it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe; the output updates on this edge |
| op_code | input | 2 | 00 hold, 01 move down, 10 move up, 11 pair swap |
| cross_phase | input | 1 | Pairing phase for pair swap |
| ring_mode | input | 1 | 0 open row, 1 closed loop |
| lane_en | input | LANES | Per-lane write enable |
| lane_in | input | LANES*WIDTH | Current lane register values |
| edge_in_lo | input | WIDTH | Value entering lane 0 on move up in the open row |
| edge_in_hi | input | WIDTH | Value entering the top lane on move down in the open row |
| lane_out | output | LANES*WIDTH | New lane values |

## Verification
Write masking and neighbour forwarding act in the same cycle. A disabled lane must keep its own value while its still-enabled neighbour loads that same value. This is provoked with random enable masks applied to moves and pair swaps in both topologies. The masks include the ring seam, where the top lane and lane 0 read each other. Every lane of the registered result is then compared with a behavioural model that builds the pairs and shifts from whole-array loops.

// File: rtl/lane_xchg_pkg.sv
`timescale 1ns/1ps
package lane_xchg_pkg;

    typedef enum logic [1:0] {
        XOP_HOLD      = 2'b00,
        XOP_TO_LOWER  = 2'b01,
        XOP_TO_UPPER  = 2'b10,
        XOP_PAIR_SWAP = 2'b11
    } xop_e;

    typedef struct packed {
        xop_e op;
        logic ring;
        logic phase;
    } xcmd_t;

    // A lane pairs with its upper neighbour when its index parity equals the phase.
    function automatic logic pairs_upward(input int unsigned idx, input logic phase);
        return (idx % 2 == 1) == phase;
    endfunction

endpackage

// File: rtl/lane_route_sel.sv
`timescale 1ns/1ps
module lane_route_sel
    import lane_xchg_pkg::*;
#(
    parameter int WIDTH    = 16,
    parameter int LANES    = 8,
    parameter int LANE_IDX = 0
) (
    input  xcmd_t             cmd,
    input  logic              wr_en,
    input  logic [WIDTH-1:0]  own_val,
    input  logic [WIDTH-1:0]  lower_nb,
    input  logic [WIDTH-1:0]  upper_nb,
    output logic [WIDTH-1:0]  next_val
);
    localparam bit IS_FIRST = (LANE_IDX == 0);
    localparam bit IS_LAST  = (LANE_IDX == LANES - 1);

    logic [WIDTH-1:0] cand;
    logic             up_pair;

    always_comb begin
        up_pair = pairs_upward(LANE_IDX, cmd.phase);
        cand    = own_val;
        unique case (cmd.op)
            XOP_HOLD:     cand = own_val;
            XOP_TO_LOWER: cand = upper_nb;
            XOP_TO_UPPER: cand = lower_nb;
            XOP_PAIR_SWAP: begin
                if (up_pair)
                    cand = (IS_LAST && !cmd.ring) ? own_val : upper_nb;
                else
                    cand = (IS_FIRST && !cmd.ring) ? own_val : lower_nb;
            end
            default:      cand = own_val;
        endcase
        next_val = wr_en ? cand : own_val;
    end

endmodule

// File: rtl/lane_out_reg.sv
`timescale 1ns/1ps
module lane_out_reg #(
    parameter int BITS = 128
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [BITS-1:0] d,
    output logic [BITS-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/lane_xchg_net.sv
`timescale 1ns/1ps
module lane_xchg_net
    import lane_xchg_pkg::*;
#(
    parameter int LANES = 8,
    parameter int WIDTH = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   op_valid,
    input  logic [1:0]             op_code,
    input  logic                   cross_phase,
    input  logic                   ring_mode,
    input  logic [LANES-1:0]       lane_en,
    input  logic [LANES*WIDTH-1:0] lane_in,
    input  logic [WIDTH-1:0]       edge_in_lo,
    input  logic [WIDTH-1:0]       edge_in_hi,
    output logic [LANES*WIDTH-1:0] lane_out
);
    localparam int TOTAL = LANES * WIDTH;
    localparam int TOP   = LANES - 1;

    xcmd_t            cmd;
    logic [WIDTH-1:0] cur   [LANES];
    logic [WIDTH-1:0] lo_nb [LANES];
    logic [WIDTH-1:0] hi_nb [LANES];
    logic [TOTAL-1:0] next_vec;

    assign cmd.op    = xop_e'(op_code);
    assign cmd.ring  = ring_mode;
    assign cmd.phase = cross_phase;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign cur[k] = lane_in[k*WIDTH +: WIDTH];

        if (k == 0) begin : g_lo_end
            assign lo_nb[k] = ring_mode ? lane_in[TOP*WIDTH +: WIDTH] : edge_in_lo;
        end else begin : g_lo_mid
            assign lo_nb[k] = lane_in[(k-1)*WIDTH +: WIDTH];
        end

        if (k == TOP) begin : g_hi_end
            assign hi_nb[k] = ring_mode ? lane_in[0 +: WIDTH] : edge_in_hi;
        end else begin : g_hi_mid
            assign hi_nb[k] = lane_in[(k+1)*WIDTH +: WIDTH];
        end

        lane_route_sel #(
            .WIDTH    (WIDTH),
            .LANES    (LANES),
            .LANE_IDX (k)
        ) u_sel (
            .cmd      (cmd),
            .wr_en    (lane_en[k]),
            .own_val  (cur[k]),
            .lower_nb (lo_nb[k]),
            .upper_nb (hi_nb[k]),
            .next_val (next_vec[k*WIDTH +: WIDTH])
        );
    end

    lane_out_reg #(.BITS(TOTAL)) u_oreg (
        .clk  (clk),
        .rst  (rst),
        .load (op_valid),
        .d    (next_vec),
        .q    (lane_out)
    );

endmodule

// File: rtl/lane_xchg_chk.sv
`timescale 1ns/1ps
module lane_xchg_chk #(
    parameter int LANES = 8,
    parameter int WIDTH = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   op_valid,
    input logic [1:0]             op_code,
    input logic                   cross_phase,
    input logic                   ring_mode,
    input logic [LANES-1:0]       lane_en,
    input logic [LANES*WIDTH-1:0] lane_in,
    input logic [WIDTH-1:0]       edge_in_lo,
    input logic [WIDTH-1:0]       edge_in_hi,
    input logic [LANES*WIDTH-1:0] lane_out
);
    localparam int TOP = LANES - 1;

    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> lane_out == '0);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(lane_out));

    p_hold_copy_r3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 2'b00) |=> lane_out == $past(lane_in));

    for (genvar k = 0; k < LANES; k++) begin : g_chk
        p_masked_keep_r10: assert property (@(posedge clk) disable iff (rst)
            (op_valid && !lane_en[k]) |=>
            lane_out[k*WIDTH +: WIDTH] == $past(lane_in[k*WIDTH +: WIDTH]));

        if (k < TOP) begin : g_dn
            p_move_down_r4: assert property (@(posedge clk) disable iff (rst)
                (op_valid && lane_en[k] && op_code == 2'b01) |=>
                lane_out[k*WIDTH +: WIDTH] == $past(lane_in[(k+1)*WIDTH +: WIDTH]));
        end
        if (k > 0) begin : g_up
            p_move_up_r5: assert property (@(posedge clk) disable iff (rst)
                (op_valid && lane_en[k] && op_code == 2'b10) |=>
                lane_out[k*WIDTH +: WIDTH] == $past(lane_in[(k-1)*WIDTH +: WIDTH]));
        end
    end

    p_open_inject_hi_r6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && lane_en[TOP] && op_code == 2'b01 && !ring_mode) |=>
        lane_out[TOP*WIDTH +: WIDTH] == $past(edge_in_hi));

    p_open_inject_lo_r6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && lane_en[0] && op_code == 2'b10 && !ring_mode) |=>
        lane_out[0 +: WIDTH] == $past(edge_in_lo));

    p_ring_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && lane_en[TOP] && op_code == 2'b01 && ring_mode) |=>
        lane_out[TOP*WIDTH +: WIDTH] == $past(lane_in[0 +: WIDTH]));

    p_pair_even_r8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && lane_en[0] && op_code == 2'b11 && !cross_phase) |=>
        lane_out[0 +: WIDTH] == $past(lane_in[WIDTH +: WIDTH]));

    p_pair_odd_open_r9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 2'b11 && cross_phase && !ring_mode) |=>
        lane_out[TOP*WIDTH +: WIDTH] == $past(lane_in[TOP*WIDTH +: WIDTH]));

endmodule

bind lane_xchg_net lane_xchg_chk #(.LANES(LANES), .WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_lane_xchg_net.sv
`timescale 1ns/1ps
module sim_lane_xchg_net;
    localparam int P = 8;
    localparam int W = 16;
    localparam int N = P * W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         op_valid = 1'b0;
    logic [1:0]   op_code = 2'b00;
    logic         cross_phase = 1'b0;
    logic         ring_mode = 1'b0;
    logic [P-1:0] lane_en = '1;
    logic [N-1:0] lane_in = '0;
    logic [W-1:0] edge_in_lo = '0;
    logic [W-1:0] edge_in_hi = '0;
    logic [N-1:0] lane_out;

    int n_checks = 0;
    int n_errors = 0;
    logic [N-1:0] exp_q[$];
    string        tag_q[$];
    logic [N-1:0] last_exp = '0;

    always #10 clk = ~clk;

    lane_xchg_net #(.LANES(P), .WIDTH(W)) u0 (.*);

    function automatic logic [N-1:0] model(input logic [1:0] op, input logic ph,
                                           input logic rg, input logic [P-1:0] en,
                                           input logic [N-1:0] din,
                                           input logic [W-1:0] lo, input logic [W-1:0] hi);
        logic [W-1:0] a [P];
        logic [W-1:0] c [P];
        logic [N-1:0] r;
        for (int i = 0; i < P; i++) begin
            a[i] = din[i*W +: W];
            c[i] = a[i];
        end
        case (op)
            2'b01: begin
                for (int i = 0; i < P-1; i++) c[i] = a[i+1];
                c[P-1] = rg ? a[0] : hi;
            end
            2'b10: begin
                for (int i = 1; i < P; i++) c[i] = a[i-1];
                c[0] = rg ? a[P-1] : lo;
            end
            2'b11: begin
                if (!ph) begin
                    for (int i = 0; i < P; i += 2) begin
                        c[i] = a[i+1];
                        c[i+1] = a[i];
                    end
                end else begin
                    for (int i = 1; i + 1 < P; i += 2) begin
                        c[i] = a[i+1];
                        c[i+1] = a[i];
                    end
                    if (rg) begin
                        c[P-1] = a[0];
                        c[0] = a[P-1];
                    end
                end
            end
            default: ;
        endcase
        for (int i = 0; i < P; i++) r[i*W +: W] = en[i] ? c[i] : a[i];
        return r;
    endfunction

    function automatic logic [N-1:0] ramp(input logic [W-1:0] base);
        logic [N-1:0] r;
        for (int i = 0; i < P; i++) r[i*W +: W] = base + W'(i);
        return r;
    endfunction

    task automatic issue(input logic v, input logic [1:0] op, input logic ph, input logic rg,
                         input logic [P-1:0] en, input logic [N-1:0] din,
                         input logic [W-1:0] lo, input logic [W-1:0] hi, input string tag);
        @(negedge clk);
        op_valid = v; op_code = op; cross_phase = ph; ring_mode = rg;
        lane_en = en; lane_in = din; edge_in_lo = lo; edge_in_hi = hi;
        if (v) last_exp = model(op, ph, rg, en, din, lo, hi);
        exp_q.push_back(last_exp);
        tag_q.push_back(tag);
    endtask

    // monitor: compare registered result half a phase after each edge
    always @(posedge clk) begin
        #5;
        if (exp_q.size() > 0) begin
            logic [N-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (lane_out !== e) begin
                n_errors++;
                $display("FAIL %s: actual %h expected %h", t, lane_out, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL R2: watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        n_checks++;
        if (lane_out !== '0) begin
            n_errors++;
            $display("FAIL R1: actual %h expected 0", lane_out);
        end
        rst = 1'b0;

        issue(1, 2'b00, 0, 0, '1, ramp(16'h1100), 16'hAAAA, 16'hBBBB, "R3 hold");
        issue(1, 2'b01, 0, 0, '1, ramp(16'h2200), 16'hAAAA, 16'hBBBB, "R4 R6 down open");
        issue(1, 2'b10, 0, 0, '1, ramp(16'h3300), 16'hCCCC, 16'hDDDD, "R5 R6 up open");
        issue(1, 2'b01, 0, 1, '1, ramp(16'h4400), 16'hAAAA, 16'hBBBB, "R4 R7 down ring");
        issue(1, 2'b10, 0, 1, '1, ramp(16'h5500), 16'hAAAA, 16'hBBBB, "R5 R7 up ring");
        issue(1, 2'b11, 0, 0, '1, ramp(16'h6600), 16'h0, 16'h0, "R8 pair even");
        issue(1, 2'b11, 1, 0, '1, ramp(16'h7700), 16'h0, 16'h0, "R9 pair odd open");
        issue(1, 2'b11, 1, 1, '1, ramp(16'h8800), 16'h0, 16'h0, "R9 pair odd ring");
        issue(1, 2'b11, 1, 1, 8'b1000_0000, ramp(16'h9900), 16'h0, 16'h0, "R10 seam mask");
        issue(1, 2'b01, 0, 0, 8'b0101_0101, ramp(16'hA000), 16'h1234, 16'h5678, "R10 R4 mask");
        issue(0, 2'b01, 0, 0, '1, ramp(16'hF000), 16'h1, 16'h2, "R2 idle hold");
        issue(0, 2'b11, 1, 1, '0, ramp(16'hE000), 16'h1, 16'h2, "R2 idle hold");

        for (int n = 0; n < 400; n++) begin
            logic [1:0] op;
            logic [N-1:0] d;
            string t;
            op = 2'($urandom);
            for (int i = 0; i < P; i++) d[i*W +: W] = W'($urandom);
            case (op)
                2'b00:   t = "R3 R10 rand hold";
                2'b01:   t = "R4 R6 R7 R10 rand down";
                2'b10:   t = "R5 R6 R7 R10 rand up";
                default: t = "R8 R9 R10 rand pair";
            endcase
            if ($urandom % 6 == 0) t = "R2 rand idle";
            issue(t != "R2 rand idle", op, 1'($urandom), 1'($urandom), P'($urandom),
                  d, W'($urandom), W'($urandom), t);
        end

        @(negedge clk);
        op_valid = 1'b0;
        repeat (3) @(negedge clk);

        rst = 1'b1;
        @(negedge clk);
        n_checks++;
        if (lane_out !== '0) begin
            n_errors++;
            $display("FAIL R1: actual %h expected 0", lane_out);
        end
        rst = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule